// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps the time of day and the calendar. The counters advance once for each pulse on a one-per-second update strobe. The host reaches every field, and the control and status bytes, through a byte-addressed register port. Seconds, minutes, hours, weekday, day of month, month, two-digit year and a century byte are each held in a register of their own.

A control byte selects the field coding and the hour mode. Fields are either packed two-digit BCD or plain binary, and hours run either 0-23 or 1-12 with a PM marker. A freeze bit in the control byte stops the counters so the host can load a new time without an update landing part way through.

An update does not happen at the moment the strobe arrives. A busy flag rises first, the counters change a fixed number of cycles later, and the flag stays high for a further fixed number of cycles. Software can therefore poll the busy flag and avoid reading the fields while they may be changing. A sticky flag records that an update has finished, and reading its register clears it.

Top module: `rtc_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00 and century (address 50) 0x20. The control byte (address 11) reads 0x02. Field addresses are seconds 0, minutes 2, hours 4, weekday 6, day 7, month 8, year 9.
- R2: Each update adds one to the seconds. The carry ripples in that same update through minutes, hours, day and weekday (weekday 7 wraps to 1), month (12 wraps to 1), year (99 wraps to 0) and century.
- R3: The day wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R4: When bit 2 of the control byte is 0, all fields are two-digit BCD (tens in bits 7:4). When it is 1, all fields are binary.
- R5: When bit 1 of the control byte is 0, hours run 1-12 and bit 7 of the hour byte is 1 for PM. The hour goes 11 AM to 12 PM, 11 PM to 12 AM (the day advances), and 12 to 1 keeping the half of the day. When the bit is 1, hours run 0-23.
- R6: While bit 7 of the control byte is 1, update strobes are ignored, the busy flag stays 0, and no field changes.
- R7: Bit 7 of address 10 is the busy flag. It reads 1 from the cycle after the strobe is sampled. The fields change LEAD_CYC cycles after that sampling edge, and the flag clears HOLD_CYC cycles after the fields change.
- R8: Bit 4 of address 12 is set when the fields change. A read of address 12 (rd high) clears it. If a read and an update fall in the same cycle, the set wins.
- R9: Address 13 always reads 0x80. Address 10 reads 0 in bits 6:0, and writes to address 10 have no effect.
- R10: A host write to a field address or to the control address stores the byte as written, and the value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle update strobe, once per second |
| addr | input | 7 | Register address |
| wr | input | 1 | Write strobe for wdata at addr |
| rd | input | 1 | Read strobe; clears the update-done flag when addr is 12 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
The hardest state to reach from the ports is a carry that ripples through every field in one update. It needs the last second of the last day of the year, in both codings and in the 12-hour mode. The stimulus reaches it by freezing the clock and writing the boundary values directly: 23:59:59 on December 31 of year 99, a February 28 and 29 with and without a leap year, and 11:59:59 PM. It then releases the freeze and issues a single strobe. A second difficult case is the busy window itself. The bench samples the busy flag and the seconds field one cycle before and one cycle after the counters change, and one cycle before and after the flag falls.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic apply;  // counters advance on this edge
    logic busy;   // update in progress flag
  } ctrlStrobes_t;

  localparam int unsigned ADR_SEC   = 0;
  localparam int unsigned ADR_MIN   = 2;
  localparam int unsigned ADR_HOUR  = 4;
  localparam int unsigned ADR_WDAY  = 6;
  localparam int unsigned ADR_MDAY  = 7;
  localparam int unsigned ADR_MON   = 8;
  localparam int unsigned ADR_YEAR  = 9;
  localparam int unsigned ADR_STATA = 10;
  localparam int unsigned ADR_CTRL  = 11;
  localparam int unsigned ADR_FLAGS = 12;
  localparam int unsigned ADR_VALID = 13;

  function automatic logic [7:0] toBin(input logic [7:0] v, input logic isBin);
    if (isBin) return v;
    return 8'(v[3:0]) + 8'(v[7:4]) * 8'd10;
  endfunction

  function automatic logic [7:0] fromBin(input logic [7:0] v, input logic isBin);
    if (isBin) return v;
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] monthLen(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                   return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         freeze,
  output ctrlStrobes_t strb
);
  localparam int unsigned MAXC = (LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_HOLD} phase_t;

  phase_t phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || freeze) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_IDLE: if (tick) begin
          phase <= ST_LEAD;
          cnt   <= CW'(LEAD_CYC - 1);
        end
        ST_LEAD: if (cnt == '0) begin
          phase <= ST_HOLD;
          cnt   <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) phase <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.busy  = (phase != ST_IDLE);
    strb.apply = (phase == ST_LEAD) && (cnt == '0) && !freeze;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CENT_ADR = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              freeze,
  output logic [7:0]        secVal,
  output logic              uefBit
);
  logic [7:0] secR, minR, hourR, wdayR, mdayR, monR, yearR, centR, ctrlR;
  logic       uefR;

  logic isBin, is24;
  assign isBin  = ctrlR[2];
  assign is24   = ctrlR[1];
  assign freeze = ctrlR[7];
  assign secVal = secR;
  assign uefBit = uefR;

  // decoded binary values
  logic [7:0] s, m, h12, h24, w, d, mo, y, c, dim;
  // next binary values
  logic [7:0] nS, nM, nH, nW, nD, nMo, nY, nC, nH12;
  logic       secC, minC, hourC, dayC, monC, yearC, nPm;
  logic [7:0] nHourByte;

  always_comb begin
    s   = toBin(secR, isBin);
    m   = toBin(minR, isBin);
    w   = toBin(wdayR, isBin);
    d   = toBin(mdayR, isBin);
    mo  = toBin(monR, isBin);
    y   = toBin(yearR, isBin);
    c   = toBin(centR, isBin);
    h12 = toBin({1'b0, hourR[6:0]}, isBin);
    if (is24)              h24 = toBin(hourR, isBin);
    else if (h12 == 8'd12) h24 = hourR[7] ? 8'd12 : 8'd0;
    else                   h24 = hourR[7] ? h12 + 8'd12 : h12;
    dim = monthLen(mo, y);

    secC  = (s >= 8'd59);
    minC  = secC && (m >= 8'd59);
    hourC = minC && (h24 >= 8'd23);
    dayC  = hourC && (d >= dim);
    monC  = dayC && (mo >= 8'd12);
    yearC = monC && (y >= 8'd99);

    nS  = secC ? 8'd0 : s + 8'd1;
    nM  = !secC ? m : (minC ? 8'd0 : m + 8'd1);
    nH  = !minC ? h24 : (hourC ? 8'd0 : h24 + 8'd1);
    nW  = !hourC ? w : ((w >= 8'd7) ? 8'd1 : w + 8'd1);
    nD  = !hourC ? d : (dayC ? 8'd1 : d + 8'd1);
    nMo = !dayC ? mo : (monC ? 8'd1 : mo + 8'd1);
    nY  = !monC ? y : (yearC ? 8'd0 : y + 8'd1);
    nC  = !yearC ? c : ((c >= 8'd99) ? 8'd0 : c + 8'd1);

    nPm  = (nH >= 8'd12);
    nH12 = (nH == 8'd0 || nH == 8'd12) ? 8'd12 : (nPm ? nH - 8'd12 : nH);
    if (is24) nHourByte = fromBin(nH, isBin);
    else      nHourByte = {nPm, fromBin(nH12, isBin)[6:0]};
  end

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; wdayR <= 8'h01;
      mdayR <= 8'h01; monR <= 8'h01; yearR <= 8'h00; centR <= 8'h20;
      ctrlR <= 8'h02; uefR <= 1'b0;
    end else begin
      if (strb.apply) begin
        secR  <= fromBin(nS, isBin);
        minR  <= fromBin(nM, isBin);
        hourR <= nHourByte;
        wdayR <= fromBin(nW, isBin);
        mdayR <= fromBin(nD, isBin);
        monR  <= fromBin(nMo, isBin);
        yearR <= fromBin(nY, isBin);
        centR <= fromBin(nC, isBin);
      end
      if (wr) begin
        if (hit(addr, ADR_SEC))  secR  <= wdata;
        if (hit(addr, ADR_MIN))  minR  <= wdata;
        if (hit(addr, ADR_HOUR)) hourR <= wdata;
        if (hit(addr, ADR_WDAY)) wdayR <= wdata;
        if (hit(addr, ADR_MDAY)) mdayR <= wdata;
        if (hit(addr, ADR_MON))  monR  <= wdata;
        if (hit(addr, ADR_YEAR)) yearR <= wdata;
        if (hit(addr, CENT_ADR)) centR <= wdata;
        if (hit(addr, ADR_CTRL)) ctrlR <= wdata;
      end
      if (strb.apply)                         uefR <= 1'b1;
      else if (rd && hit(addr, ADR_FLAGS))    uefR <= 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if      (hit(addr, ADR_SEC))   rdata = secR;
    else if (hit(addr, ADR_MIN))   rdata = minR;
    else if (hit(addr, ADR_HOUR))  rdata = hourR;
    else if (hit(addr, ADR_WDAY))  rdata = wdayR;
    else if (hit(addr, ADR_MDAY))  rdata = mdayR;
    else if (hit(addr, ADR_MON))   rdata = monR;
    else if (hit(addr, ADR_YEAR))  rdata = yearR;
    else if (hit(addr, CENT_ADR))  rdata = centR;
    else if (hit(addr, ADR_STATA)) rdata = {strb.busy, 7'b0};
    else if (hit(addr, ADR_CTRL))  rdata = ctrlR;
    else if (hit(addr, ADR_FLAGS)) rdata = {3'b0, uefR, 4'b0};
    else if (hit(addr, ADR_VALID)) rdata = 8'h80;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CENT_ADR = 50,
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  ctrlStrobes_t strb;
  logic       freezeBit;
  logic [7:0] secVal;
  logic       uefBit;

  rtc_ctrl #(.LEAD_CYC(LEAD_CYC), .HOLD_CYC(HOLD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .freeze(freezeBit), .strb(strb)
  );

  rtc_datapath #(.ADDR_W(ADDR_W), .CENT_ADR(CENT_ADR)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .freeze(freezeBit), .secVal(secVal),
    .uefBit(uefBit)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              apply,
  input logic              freeze,
  input logic [7:0]        secVal,
  input logic              uefBit
);
  AST_SEC_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!wr && !busy) |=> $stable(secVal)); // R7
  AST_FREEZE_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> !busy); // R6
  AST_DONE_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    apply |=> uefBit); // R8
  AST_DONE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rd && addr == ADDR_W'(12) && !apply) |=> !uefBit); // R8
  AST_APPLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    apply |-> busy); // R7
endmodule

bind rtc_core rtc_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wr(wr), .rd(rd), .addr(addr), .busy(strb.busy),
  .apply(strb.apply), .freeze(freezeBit), .secVal(secVal), .uefBit(uefBit)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  localparam int LEAD = 4;
  localparam int HOLD = 3;

  logic clk = 0, rstN = 0, tick = 0, wr = 0, rd = 0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  rtc_core #(.LEAD_CYC(LEAD), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [7:0] v);
    @(negedge clk); addr = 7'(a); wdata = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rdReg(input int a, output logic [7:0] v);
    addr = 7'(a); #1; v = rdata;
  endtask

  task automatic expReg(input string req, input int a, input logic [7:0] e);
    logic [7:0] v;
    rdReg(a, v); check(req, v, e);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic fullUpdate();
    pulseTick();
    repeat (LEAD + HOLD + 1) @(negedge clk);
  endtask

  task automatic loadTime(input logic [7:0] ctl, input logic [7:0] s, mi, h, w, d, mo, y);
    wrReg(11, ctl | 8'h80);
    wrReg(0, s); wrReg(2, mi); wrReg(4, h); wrReg(6, w);
    wrReg(7, d); wrReg(8, mo); wrReg(9, y);
    wrReg(11, ctl);
  endtask

  task automatic testReset();
    @(negedge clk);
    expReg("R1 sec", 0, 8'h00); expReg("R1 min", 2, 8'h00);
    expReg("R1 hour", 4, 8'h00); expReg("R1 wday", 6, 8'h01);
    expReg("R1 mday", 7, 8'h01); expReg("R1 mon", 8, 8'h01);
    expReg("R1 year", 9, 8'h00); expReg("R1 cent", 50, 8'h20);
    expReg("R1 ctrl", 11, 8'h02);
    expReg("R9 valid", 13, 8'h80);
  endtask

  task automatic testBcdRipple();
    loadTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    fullUpdate();
    expReg("R2 sec", 0, 8'h00); expReg("R2 min", 2, 8'h00);
    expReg("R2 hour", 4, 8'h00); expReg("R2 wday", 6, 8'h01);
    expReg("R2 mday", 7, 8'h01); expReg("R2 mon", 8, 8'h01);
    expReg("R2 year", 9, 8'h00); expReg("R2 cent", 50, 8'h21);
    // simple BCD digit carry R4
    loadTime(8'h02, 8'h09, 8'h19, 8'h09, 8'h03, 8'h15, 8'h06, 8'h42);
    fullUpdate();
    expReg("R4 bcd sec", 0, 8'h10);
  endtask

  task automatic testBinaryLeap();
    // R4 binary coding, R3 leap February
    loadTime(8'h06, 8'd59, 8'd59, 8'd23, 8'd2, 8'd28, 8'd2, 8'd24);
    fullUpdate();
    expReg("R3 leap day", 7, 8'd29); expReg("R3 leap mon", 8, 8'd2);
    expReg("R4 bin wday", 6, 8'd3);
    loadTime(8'h06, 8'd59, 8'd59, 8'd23, 8'd2, 8'd29, 8'd2, 8'd24);
    fullUpdate();
    expReg("R3 after leap day", 7, 8'd1); expReg("R3 after leap mon", 8, 8'd3);
    loadTime(8'h06, 8'd59, 8'd59, 8'd23, 8'd2, 8'd28, 8'd2, 8'd23);
    fullUpdate();
    expReg("R3 common day", 7, 8'd1); expReg("R3 common mon", 8, 8'd3);
    loadTime(8'h06, 8'd9, 8'd0, 8'd0, 8'd1, 8'd5, 8'd5, 8'd5);
    fullUpdate();
    expReg("R4 bin sec", 0, 8'd10);
    // 30-day month in BCD
    loadTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h10);
    fullUpdate();
    expReg("R3 april day", 7, 8'h01); expReg("R3 april mon", 8, 8'h05);
    loadTime(8'h02, 8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h05, 8'h10);
    fullUpdate();
    expReg("R3 may 31", 7, 8'h31);
  endtask

  task automatic testTwelveHour();
    loadTime(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h03, 8'h20);
    fullUpdate();
    expReg("R5 11AM to 12PM", 4, 8'h92);
    expReg("R5 day kept", 7, 8'h10);
    loadTime(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h03, 8'h20);
    fullUpdate();
    expReg("R5 11PM to 12AM", 4, 8'h12);
    expReg("R5 day advanced", 7, 8'h11);
    loadTime(8'h00, 8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h03, 8'h20);
    fullUpdate();
    expReg("R5 12AM to 1AM", 4, 8'h01);
    loadTime(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h03, 8'h20);
    fullUpdate();
    expReg("R5 12PM to 1PM", 4, 8'h81);
    loadTime(8'h02, 8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h03, 8'h20);
    fullUpdate();
    expReg("R5 24h 12 to 13", 4, 8'h13);
  endtask

  task automatic testFreeze();
    loadTime(8'h02, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wrReg(11, 8'h82);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    expReg("R6 busy stays low", 10, 8'h00);
    repeat (LEAD + HOLD + 1) @(negedge clk);
    expReg("R6 sec frozen", 0, 8'h30);
    wrReg(11, 8'h02);
    expReg("R10 ctrl readback", 11, 8'h02);
  endtask

  task automatic testBusyWindow();
    logic [7:0] v;
    // clear done flag via read
    @(negedge clk); addr = 7'd12; rd = 1;
    @(negedge clk); rd = 0;
    expReg("R8 cleared by read", 12, 8'h00);
    loadTime(8'h02, 8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    pulseTick();
    expReg("R7 busy after strobe", 10, 8'h80);
    repeat (LEAD - 1) @(negedge clk);
    expReg("R7 sec before change", 0, 8'h05);
    expReg("R7 busy before change", 10, 8'h80);
    expReg("R8 flag not yet set", 12, 8'h00);
    @(negedge clk);
    expReg("R7 sec changed", 0, 8'h06);
    expReg("R8 flag set", 12, 8'h10);
    repeat (HOLD - 1) @(negedge clk);
    expReg("R7 busy before fall", 10, 8'h80);
    @(negedge clk);
    expReg("R7 busy fallen", 10, 8'h00);
    rdReg(12, v); check("R8 flag sticky", v, 8'h10);
    @(negedge clk); addr = 7'd12; rd = 1;
    @(negedge clk); rd = 0;
    expReg("R8 flag read-cleared", 12, 8'h00);
  endtask

  task automatic testStatusWrites();
    wrReg(10, 8'hFF);
    expReg("R9 status A ignores writes", 10, 8'h00);
    wrReg(13, 8'h00);
    expReg("R9 valid constant", 13, 8'h80);
    wrReg(50, 8'h19);
    expReg("R10 century write", 50, 8'h19);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testBcdRipple();
    testBinaryLeap();
    testTwelveHour();
    testFreeze();
    testBusyWindow();
    testStatusWrites();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule